// File: doc/BRIEF.md
# Delayed Conditional Branch Unit

This block resolves the relative branches of a 16-bit graphics coprocessor core. When an instruction issues, the unit receives the opcode, the byte already prefetched behind it (the signed branch displacement), the address of that displacement byte, the last arithmetic result and the carry and overflow flags. From the opcode it picks one of eleven conditions and evaluates it. It then produces the next fetch address and a one-cycle taken pulse.

The byte after the displacement is always fetched and executed, whether the branch is taken or not. That instruction is a delay slot, and its address is also an output. A taken branch lands at the delay-slot address plus the sign-extended displacement. A branch that is not taken steps one position past the delay slot. All address arithmetic wraps modulo 2^16. Opcodes that are not branches leave every output quiet and unchanged.

Top module: `br_delay_unit`

## Requirements
- R1: Opcode 0x05 is unconditional: when issued it is always taken, whatever the flags are.
- R2: A taken branch sets next_pc to pc_off + 1 + the displacement. The displacement is offset_byte as an 8-bit two's-complement value, sign-extended to 16 bits, and the sum wraps modulo 2^16.
- R3: On every resolved branch, slot_pc equals pc_off + 1 (mod 2^16), which is the delay-slot address, taken or not.
- R4: A branch that is not taken sets next_pc to pc_off + 2 (mod 2^16).
- R5: Opcode 0x06 is taken when last_result[15] differs from ovf_flag. Opcode 0x07 is taken when they are equal.
- R6: Opcode 0x08 is taken when last_result[15:0] is nonzero. Opcode 0x09 is taken when it is zero.
- R7: Opcode 0x0A is taken when last_result[15] is 0. Opcode 0x0B is taken when it is 1.
- R8: Opcodes 0x0C and 0x0D are taken when carry_flag is 0 and 1 respectively. Opcodes 0x0E and 0x0F are taken when ovf_flag is 0 and 1 respectively.
- R9: br_resolved, br_taken, next_pc and slot_pc are registered. They update on the first rising edge after the issue and hold the result for that cycle only. With no new branch, br_resolved and br_taken are 0 on the following cycle.
- R10: An issue with an opcode outside 0x05..0x0F, or a cycle with issue_valid low, leaves br_resolved and br_taken at 0 and keeps next_pc and slot_pc unchanged.
- R11: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| opcode | input | 8 | Opcode of the issuing instruction |
| offset_byte | input | 8 | Prefetched byte after the opcode (branch displacement) |
| pc_off | input | 16 | Address of the displacement byte |
| last_result | input | 16 | Last arithmetic result (source of sign and zero) |
| carry_flag | input | 1 | Carry flag |
| ovf_flag | input | 1 | Overflow flag |
| br_resolved | output | 1 | A branch resolved in the previous cycle |
| br_taken | output | 1 | The resolved branch was taken |
| next_pc | output | 16 | Next program counter after the delay slot |
| slot_pc | output | 16 | Address of the delay-slot instruction |

## Verification
All 256 opcode values are issued against sixteen flag situations. These are four results (zero, positive nonzero, 0x8000 and 0xFFFF) crossed with every carry/overflow pair. This separates each condition from its partner and from the other flags, and it shows that the opcodes which are not branches change nothing. The unconditional and the equal branch are then driven with every displacement from 0 to 255 at program counters near 0x0000, 0x7FFE and 0xFFFE. This exposes mistakes in sign extension and wraparound on both the taken and the fall-through path. An idle cycle after each issue shows that the result pulse lasts exactly one cycle.

// File: rtl/br_pkg.sv
package br_pkg;
   typedef enum logic [3:0] {
      CND_ALWAYS, CND_LT, CND_GE, CND_NE, CND_EQ, CND_PL,
      CND_MI, CND_CC, CND_CS, CND_VC, CND_VS, CND_NONE
   } br_cond_e;

   localparam int unsigned BR_FIRST_OPC = 5;
   localparam int unsigned BR_COUNT     = 11;
endpackage

// File: rtl/br_cond_decode.sv
module br_cond_decode import br_pkg::*; #(
   parameter int unsigned OP_W = 8
) (
   input  logic [OP_W-1:0] opcode,
   output br_cond_e        cond,
   output logic            is_branch
);
   localparam logic [OP_W-1:0] FIRST = OP_W'(BR_FIRST_OPC);
   localparam logic [OP_W-1:0] LAST  = OP_W'(BR_FIRST_OPC + BR_COUNT - 1);

   logic [OP_W-1:0] rel;

   always_comb begin
      rel       = opcode - FIRST;
      is_branch = (opcode >= FIRST) && (opcode <= LAST);
      cond      = CND_NONE;
      if (is_branch) begin
         case (rel[3:0])
            4'd0:    cond = CND_ALWAYS;
            4'd1:    cond = CND_LT;
            4'd2:    cond = CND_GE;
            4'd3:    cond = CND_NE;
            4'd4:    cond = CND_EQ;
            4'd5:    cond = CND_PL;
            4'd6:    cond = CND_MI;
            4'd7:    cond = CND_CC;
            4'd8:    cond = CND_CS;
            4'd9:    cond = CND_VC;
            4'd10:   cond = CND_VS;
            default: cond = CND_NONE;
         endcase
      end
   end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval import br_pkg::*; #(
   parameter int unsigned DATA_W = 16
) (
   input  br_cond_e          cond,
   input  logic [DATA_W-1:0] result,
   input  logic              carry,
   input  logic              ovf,
   output logic              pass
);
   logic sgn, zro;

   always_comb begin
      sgn = result[DATA_W-1];
      zro = ~|result;
      case (cond)
         CND_ALWAYS: pass = 1'b1;
         CND_LT:     pass = sgn ^ ovf;
         CND_GE:     pass = ~(sgn ^ ovf);
         CND_NE:     pass = ~zro;
         CND_EQ:     pass = zro;
         CND_PL:     pass = ~sgn;
         CND_MI:     pass = sgn;
         CND_CC:     pass = ~carry;
         CND_CS:     pass = carry;
         CND_VC:     pass = ~ovf;
         CND_VS:     pass = ovf;
         default:    pass = 1'b0;
      endcase
   end
endmodule

// File: rtl/br_target.sv
module br_target #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned OFF_W  = 8
) (
   input  logic [ADDR_W-1:0] pc_off,
   input  logic [OFF_W-1:0]  disp,
   output logic [ADDR_W-1:0] slot_addr,
   output logic [ADDR_W-1:0] jump_addr,
   output logic [ADDR_W-1:0] fall_addr
);
   logic [ADDR_W-1:0] disp_ext;

   generate
      if (OFF_W == ADDR_W) begin : g_full
         assign disp_ext = disp;
      end else begin : g_sext
         assign disp_ext = {{(ADDR_W-OFF_W){disp[OFF_W-1]}}, disp};
      end
   endgenerate

   assign slot_addr = pc_off + ADDR_W'(1);
   assign jump_addr = slot_addr + disp_ext;
   assign fall_addr = slot_addr + ADDR_W'(1);
endmodule

// File: rtl/br_delay_unit.sv
module br_delay_unit import br_pkg::*; #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned OFF_W  = 8,
   parameter int unsigned OP_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic [OP_W-1:0]   opcode,
   input  logic [OFF_W-1:0]  offset_byte,
   input  logic [ADDR_W-1:0] pc_off,
   input  logic [DATA_W-1:0] last_result,
   input  logic              carry_flag,
   input  logic              ovf_flag,
   output logic              br_resolved,
   output logic              br_taken,
   output logic [ADDR_W-1:0] next_pc,
   output logic [ADDR_W-1:0] slot_pc
);
   generate
      if (OFF_W > ADDR_W) begin : g_bad_off
         $error("displacement wider than address");
      end
      if (OP_W < 4) begin : g_bad_op
         $error("opcode too narrow for branch range");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("result width too small");
      end
   endgenerate

   br_cond_e          cond;
   logic              is_br, pass;
   logic [ADDR_W-1:0] slot_a, jump_a, fall_a;

   br_cond_decode #(.OP_W(OP_W)) i_dec (
      .opcode(opcode), .cond(cond), .is_branch(is_br));

   br_cond_eval #(.DATA_W(DATA_W)) i_eval (
      .cond(cond), .result(last_result), .carry(carry_flag),
      .ovf(ovf_flag), .pass(pass));

   br_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_tgt (
      .pc_off(pc_off), .disp(offset_byte), .slot_addr(slot_a),
      .jump_addr(jump_a), .fall_addr(fall_a));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         br_resolved <= 1'b0;
         br_taken    <= 1'b0;
         next_pc     <= '0;
         slot_pc     <= '0;
      end else if (issue_valid && is_br) begin
         br_resolved <= 1'b1;
         br_taken    <= pass;
         next_pc     <= pass ? jump_a : fall_a;
         slot_pc     <= slot_a;
      end else begin
         br_resolved <= 1'b0;
         br_taken    <= 1'b0;
      end
   end
endmodule

// File: rtl/br_delay_unit_chk.sv
module br_delay_unit_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned OFF_W  = 8,
   parameter int unsigned OP_W   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_valid,
   input logic [OP_W-1:0]   opcode,
   input logic [OFF_W-1:0]  offset_byte,
   input logic [ADDR_W-1:0] pc_off,
   input logic              br_resolved,
   input logic              br_taken,
   input logic [ADDR_W-1:0] next_pc,
   input logic [ADDR_W-1:0] slot_pc
);
   logic              in_range;
   logic [ADDR_W-1:0] sx;

   assign in_range = (opcode >= OP_W'(5)) && (opcode <= OP_W'(15));
   assign sx = {{(ADDR_W-OFF_W){offset_byte[OFF_W-1]}}, offset_byte};

   assert_always_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && opcode == OP_W'(5) |=> br_taken);

   assert_jump_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && in_range |=> !br_taken ||
         next_pc == $past(pc_off) + ADDR_W'(1) + $past(sx));

   assert_slot_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && in_range |=> br_resolved && slot_pc == $past(pc_off) + ADDR_W'(1));

   assert_fall_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && in_range |=> br_taken || next_pc == $past(pc_off) + ADDR_W'(2));

   assert_taken_in_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |-> br_resolved);

   assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_valid && in_range) |=> !br_resolved && !br_taken &&
         $stable(next_pc) && $stable(slot_pc));
endmodule

bind br_delay_unit br_delay_unit_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .OP_W(OP_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
   .offset_byte(offset_byte), .pc_off(pc_off), .br_resolved(br_resolved),
   .br_taken(br_taken), .next_pc(next_pc), .slot_pc(slot_pc)
);

// File: tb/test_br_delay_unit.sv
module test_br_delay_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic [7:0]  opcode = '0;
   logic [7:0]  offset_byte = '0;
   logic [15:0] pc_off = '0;
   logic [15:0] last_result = '0;
   logic        carry_flag = 1'b0;
   logic        ovf_flag = 1'b0;
   logic        br_resolved, br_taken;
   logic [15:0] next_pc, slot_pc;

   int checks = 0;
   int fails  = 0;
   logic [15:0] exp_npc = '0;
   logic [15:0] exp_slot = '0;

   always #4 clk = ~clk;

   br_delay_unit i_br_delay_unit (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
      .offset_byte(offset_byte), .pc_off(pc_off), .last_result(last_result),
      .carry_flag(carry_flag), .ovf_flag(ovf_flag), .br_resolved(br_resolved),
      .br_taken(br_taken), .next_pc(next_pc), .slot_pc(slot_pc));

   task automatic check(input bit ok, input string req,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic bit model(input logic [7:0] op, input logic [15:0] res,
                                input logic c, input logic v);
      bit s, z;
      s = res[15];
      z = (res == 16'h0000);
      case (op)
         8'h05: return 1'b1;           // R1
         8'h06: return s != v;         // R5
         8'h07: return s == v;         // R5
         8'h08: return !z;             // R6
         8'h09: return z;              // R6
         8'h0A: return !s;             // R7
         8'h0B: return s;              // R7
         8'h0C: return !c;             // R8
         8'h0D: return c;              // R8
         8'h0E: return !v;             // R8
         8'h0F: return v;              // R8
         default: return 1'b0;
      endcase
   endfunction

   task automatic issue(input logic [7:0] op, input logic [7:0] off,
                        input logic [15:0] p, input logic [15:0] res,
                        input logic c, input logic v, input logic vld);
      bit br, t;
      @(negedge clk);
      issue_valid = vld; opcode = op; offset_byte = off; pc_off = p;
      last_result = res; carry_flag = c; ovf_flag = v;
      br = vld && op >= 8'h05 && op <= 8'h0F;
      t  = br && model(op, res, c, v);
      @(negedge clk);
      issue_valid = 1'b0;
      if (br) begin
         exp_slot = p + 16'd1;
         exp_npc  = t ? p + 16'd1 + {{8{off[7]}}, off} : p + 16'd2;
         check(br_resolved == 1'b1, "R9 resolved", 16'(br_resolved), 16'd1);
         check(br_taken == t, "R1/R5-R8 condition (R5 R6 R7 R8)", 16'(br_taken), 16'(t));
         check(next_pc == exp_npc, t ? "R2 target" : "R4 fall-through", next_pc, exp_npc);
         check(slot_pc == exp_slot, "R3 slot", slot_pc, exp_slot);
      end else begin
         check(!br_resolved && !br_taken, "R10 quiet flags",
               {14'd0, br_resolved, br_taken}, 16'd0);
         check(next_pc == exp_npc && slot_pc == exp_slot, "R10 hold",
               next_pc ^ slot_pc, exp_npc ^ exp_slot);
      end
      @(negedge clk);
      check(!br_resolved && !br_taken, "R9 pulse ends",
            {14'd0, br_resolved, br_taken}, 16'd0);
   endtask

   initial begin
      logic [15:0] results [4];
      logic [15:0] pcs [4];
      results[0] = 16'h0000; results[1] = 16'h0001;
      results[2] = 16'h8000; results[3] = 16'hFFFF;
      pcs[0] = 16'h0000; pcs[1] = 16'h7FFE; pcs[2] = 16'hFFFE; pcs[3] = 16'h1234;
      repeat (3) @(negedge clk);
      check(!br_resolved && !br_taken && next_pc == 0 && slot_pc == 0,
            "R11 reset", next_pc | slot_pc | {14'd0, br_resolved, br_taken}, 16'd0);
      rst_n = 1'b1;
      for (int op = 0; op < 256; op++)
         for (int f = 0; f < 16; f++)
            issue(8'(op), 8'(op * 7 + f), 16'(op * 257 + f * 4099),
                  results[f[3:2]], f[1], f[0], 1'b1);
      issue(8'h05, 8'h10, 16'h4000, 16'h0, 1'b0, 1'b0, 1'b0); // R10 valid low
      for (int p = 0; p < 4; p++)
         for (int d = 0; d < 256; d++) begin
            issue(8'h05, 8'(d), pcs[p], 16'h0001, 1'b0, 1'b0, 1'b1); // R1 R2
            issue(8'h09, 8'(d), pcs[p], 16'(d & 1), 1'b1, 1'b1, 1'b1); // R6 R4
         end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule